// File: doc/BRIEF.md
# Banked Program Counter Branch Unit

This block keeps the program counter for a core whose program space is split into eight 64 KB blocks, and each clock it chooses the next fetch address. A 16-bit counter sits under a 3-bit block field. Together they form a 19-bit fetch address, which covers 512 KB. Every cycle the core raises at most one kind of request:

- advance by the length of the current instruction;
- take a conditional relative branch with a signed 8-bit displacement;
- jump or call to an absolute 16-bit target;
- jump indirectly to a 16-bit base plus an 8-bit index.

All of these only change the low 16 bits. They wrap around inside the current block and never carry into the block field. The block field changes only through its own load port. Call stack storage lives elsewhere. A call reaches this block as an absolute target.

Top module: `pcbr_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, both the block field and the counter become zero, so `fetch_addr` reads 0 after that edge.
- R2: A sequential step (`seq_en`) sets the counter to counter + `seq_len`, modulo 65536.
- R3: An absolute transfer (`abs_en`) loads `abs_target` into the counter on the next edge.
- R4: A relative branch (`rel_en`) with `rel_cond`=1 sets the counter to counter + `seq_len` + sign-extended `rel_disp`, modulo 65536. Bit 7 of `rel_disp` is the sign bit.
- R5: A relative branch with `rel_cond`=0 sets the counter to counter + `seq_len`, modulo 65536.
- R6: An indirect jump (`ind_en`) sets the counter to `ind_base` + zero-extended `ind_index`, modulo 65536.
- R7: When several requests are raised together, only one acts, in this priority order: absolute, then indirect, then relative, then sequential.
- R8: With no request raised, the counter holds its value.
- R9: `blk_load` copies `blk_value` into the block field on the next edge. The counter updates independently in the same cycle.
- R10: No counter operation ever changes the block field, including a wrap past 0xFFFF or below 0.
- R11: `fetch_addr` is `{block, counter}` and is driven straight from registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_en | input | 1 | Sequential step request |
| seq_len | input | 3 | Instruction length in bytes |
| rel_en | input | 1 | Relative branch request |
| rel_cond | input | 1 | Branch condition, 1 = taken |
| rel_disp | input | 8 | Signed branch displacement |
| abs_en | input | 1 | Absolute jump or call request |
| abs_target | input | 16 | Absolute target inside the block |
| ind_en | input | 1 | Indirect jump request |
| ind_base | input | 16 | Base register value |
| ind_index | input | 8 | Unsigned index register value |
| blk_load | input | 1 | Block field load strobe |
| blk_value | input | 3 | New block field value |
| fetch_addr | output | 19 | Registered fetch address `{block, counter}` |

## Verification
The relative branch is swept over all 256 displacements and every length from 0 to 7. These sweeps start from counters near 0x0000 and near 0xFFFF, so sign extension and both wrap directions are checked against a bench sum, each in taken and not-taken form. The indirect jump is swept over all 256 indices on a base near the top of the block. This separates zero extension from sign extension and shows whether a carry leaks into the block field. The bench also raises requests in combination to confirm the priority order. It also sets the block field while other transfers are taking place, which shows that the block field and the counter are updated independently.

// File: rtl/pcbr_pkg.sv
package pcbr_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_SEQ  = 3'd1,
    SRC_REL  = 3'd2,
    SRC_IND  = 3'd3,
    SRC_ABS  = 3'd4
  } nxt_src_e;
endpackage

// File: rtl/pcbr_arb.sv
module pcbr_arb
  import pcbr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     seq_en,
  input  logic     rel_en,
  input  logic     ind_en,
  input  logic     abs_en,
  output nxt_src_e src
);
  always_comb begin
    if (abs_en)      src = SRC_ABS;
    else if (ind_en) src = SRC_IND;
    else if (rel_en) src = SRC_REL;
    else if (seq_en) src = SRC_SEQ;
    else             src = SRC_HOLD;
  end

  AST_ABS_WINS: assert property (@(posedge clk) disable iff (rst)
    abs_en |-> src == SRC_ABS); // R7
  AST_IND_OVER_REL: assert property (@(posedge clk) disable iff (rst)
    (ind_en && !abs_en) |-> src == SRC_IND); // R7
endmodule

// File: rtl/pcbr_target.sv
module pcbr_target
  import pcbr_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int LEN_W = 3,
  parameter int OFF_W = 8,
  parameter int IDX_W = 8
) (
  input  nxt_src_e          src,
  input  logic [PC_W-1:0]   pc_cur,
  input  logic [LEN_W-1:0]  seq_len,
  input  logic              rel_cond,
  input  logic [OFF_W-1:0]  rel_disp,
  input  logic [PC_W-1:0]   abs_target,
  input  logic [PC_W-1:0]   ind_base,
  input  logic [IDX_W-1:0]  ind_index,
  output logic [PC_W-1:0]   pc_next
);
  localparam int LEN_PAD = PC_W - LEN_W;
  localparam int OFF_PAD = PC_W - OFF_W;
  localparam int IDX_PAD = PC_W - IDX_W;

  logic [PC_W-1:0] len_ext, disp_ext, idx_ext, seq_pc, rel_pc, ind_pc;

  assign len_ext  = {{LEN_PAD{1'b0}}, seq_len};
  assign disp_ext = {{OFF_PAD{rel_disp[OFF_W-1]}}, rel_disp};
  assign idx_ext  = {{IDX_PAD{1'b0}}, ind_index};
  assign seq_pc   = pc_cur + len_ext;
  assign rel_pc   = rel_cond ? seq_pc + disp_ext : seq_pc;
  assign ind_pc   = ind_base + idx_ext;

  always_comb begin
    unique case (src)
      SRC_SEQ: pc_next = seq_pc;
      SRC_REL: pc_next = rel_pc;
      SRC_IND: pc_next = ind_pc;
      SRC_ABS: pc_next = abs_target;
      default: pc_next = pc_cur;
    endcase
  end
endmodule

// File: rtl/pcbr_regs.sv
module pcbr_regs #(
  parameter int PC_W  = 16,
  parameter int BLK_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PC_W-1:0]       pc_next,
  input  logic                  blk_load,
  input  logic [BLK_W-1:0]      blk_value,
  output logic [PC_W-1:0]       pc_q,
  output logic [BLK_W+PC_W-1:0] fetch_addr
);
  logic [BLK_W-1:0] blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      blk_q <= '0;
    end else begin
      pc_q <= pc_next;
      if (blk_load) blk_q <= blk_value;
    end
  end

  assign fetch_addr = {blk_q, pc_q};

  AST_BLK_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (rst)
    !blk_load |=> $stable(blk_q)); // R10
  AST_BLK_LOADED: assert property (@(posedge clk) disable iff (rst)
    blk_load |=> blk_q == $past(blk_value)); // R9
endmodule

// File: rtl/pcbr_unit.sv
module pcbr_unit
  import pcbr_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int BLK_W = 3,
  parameter int LEN_W = 3,
  parameter int OFF_W = 8,
  parameter int IDX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  seq_en,
  input  logic [LEN_W-1:0]      seq_len,
  input  logic                  rel_en,
  input  logic                  rel_cond,
  input  logic [OFF_W-1:0]      rel_disp,
  input  logic                  abs_en,
  input  logic [PC_W-1:0]       abs_target,
  input  logic                  ind_en,
  input  logic [PC_W-1:0]       ind_base,
  input  logic [IDX_W-1:0]      ind_index,
  input  logic                  blk_load,
  input  logic [BLK_W-1:0]      blk_value,
  output logic [BLK_W+PC_W-1:0] fetch_addr
);
  nxt_src_e        src;
  logic [PC_W-1:0] pc_q, pc_next;

  pcbr_arb u_arb (
    .clk(clk), .rst(rst), .seq_en(seq_en), .rel_en(rel_en),
    .ind_en(ind_en), .abs_en(abs_en), .src(src)
  );

  pcbr_target #(.PC_W(PC_W), .LEN_W(LEN_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
    .src(src), .pc_cur(pc_q), .seq_len(seq_len), .rel_cond(rel_cond),
    .rel_disp(rel_disp), .abs_target(abs_target), .ind_base(ind_base),
    .ind_index(ind_index), .pc_next(pc_next)
  );

  pcbr_regs #(.PC_W(PC_W), .BLK_W(BLK_W)) u_regs (
    .clk(clk), .rst(rst), .pc_next(pc_next), .blk_load(blk_load),
    .blk_value(blk_value), .pc_q(pc_q), .fetch_addr(fetch_addr)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> fetch_addr == '0); // R1
  AST_ABS_TARGET: assert property (@(posedge clk) disable iff (rst)
    abs_en |=> fetch_addr[PC_W-1:0] == $past(abs_target)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!seq_en && !rel_en && !abs_en && !ind_en) |=> $stable(fetch_addr[PC_W-1:0])); // R8
endmodule

// File: tb/sim_pcbr_unit.sv
module sim_pcbr_unit;
  logic        clk = 0, rst = 1;
  logic        seq_en = 0, rel_en = 0, rel_cond = 0, abs_en = 0, ind_en = 0, blk_load = 0;
  logic [2:0]  seq_len = 0, blk_value = 0;
  logic [7:0]  rel_disp = 0, ind_index = 0;
  logic [15:0] abs_target = 0, ind_base = 0;
  logic [18:0] fetch_addr;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [2:0]  eb;
  logic [15:0] ep;

  always #5 clk = ~clk;

  pcbr_unit u0 (.*);

  task automatic chk(input string req, input logic [18:0] exp);
    checks++;
    if (fetch_addr !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, fetch_addr, exp);
    end
  endtask

  task automatic idle();
    seq_en = 0; rel_en = 0; abs_en = 0; ind_en = 0; blk_load = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic go_abs(input logic [15:0] t);
    idle(); abs_en = 1; abs_target = t; tick(); idle(); ep = t;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    chk("R1", 19'h0);
    rst = 0; eb = 0; ep = 0;
    // R8 idle holds
    tick(); chk("R8", 19'h0);
    // R2 sequential, with wrap
    go_abs(16'hFFFC);
    for (int l = 0; l < 8; l++) begin
      seq_en = 1; seq_len = 3'(l); tick(); idle();
      ep = ep + 16'(l); chk("R2 R10", {eb, ep});
    end
    // R9 block load with simultaneous jump
    blk_load = 1; blk_value = 3'd5; abs_en = 1; abs_target = 16'h1234; tick(); idle();
    eb = 5; ep = 16'h1234; chk("R9 R3", {eb, ep});
    // R4/R5 relative sweep from two starting points
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 2; c++) begin
        for (int l = 0; l < 8; l++) begin
          for (int d = 0; d < 256; d++) begin
            logic [15:0] start, de;
            start = (s == 0) ? 16'h0002 : 16'hFFF8;
            go_abs(start);
            rel_en = 1; rel_cond = c[0]; seq_len = 3'(l); rel_disp = 8'(d);
            tick(); idle();
            de = {{8{rel_disp[7]}}, rel_disp};
            ep = start + 16'(l) + (c == 1 ? de : 16'h0);
            chk(c == 1 ? "R4 R10" : "R5", {eb, ep});
          end
        end
      end
    end
    // R6 indirect sweep
    for (int i = 0; i < 256; i++) begin
      ind_en = 1; ind_base = 16'hFF90; ind_index = 8'(i); tick(); idle();
      ep = 16'hFF90 + 16'(i); chk("R6 R10", {eb, ep});
    end
    // R7 priority
    seq_en = 1; seq_len = 3; rel_en = 1; rel_cond = 1; rel_disp = 8'h10;
    ind_en = 1; ind_base = 16'h4000; ind_index = 8'h22; abs_en = 1; abs_target = 16'h0777;
    tick(); idle(); ep = 16'h0777; chk("R7 abs", {eb, ep});
    seq_en = 1; rel_en = 1; ind_en = 1; tick(); idle(); ep = 16'h4022; chk("R7 ind", {eb, ep});
    seq_en = 1; rel_en = 1; tick(); idle(); ep = 16'h4022 + 16'h13; chk("R7 rel", {eb, ep});
    // R9 load with sequential, R8 hold with block
    blk_load = 1; blk_value = 3'd7; seq_en = 1; seq_len = 2; tick(); idle();
    eb = 7; ep = ep + 16'd2; chk("R9", {eb, ep});
    tick(); chk("R8 R11", {eb, ep});
    // R1 reset again
    rst = 1; tick(); rst = 0; chk("R1", 19'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule